// File: doc/BRIEF.md
# Three-wire serial EEPROM device controller

This block is the device end of a three-wire synchronous serial memory. A host selects the device with a chip select, supplies a serial clock and a data input line, and receives answers on one data output that is released to high impedance when the device is not talking. Each transaction opens with a start bit and a two-bit opcode, followed by an address whose width depends on a static organisation select input. The command is then executed against an on-chip register array that holds either 16-bit words or, with the select low, twice as many 8-bit bytes.

The seven commands are read, erase/write enable, erase/write disable, erase one word, write one word, erase everything and write everything. A write-protect latch guards every modifying command. A modifying command starts a programming period that a cycle-count timer models. While chip select stays high, the data output reports whether that period has ended. The serial inputs are sampled in the system clock domain, and the data output is modelled as a value plus an enable.

Top module: `serial_eeprom_slave`

## Requirements
- R1: With chip select high and no command in progress, a 0 on data in is ignored at each serial clock rising edge and a 1 is taken as a start bit. The two bits after it are the opcode: 10 is read, 01 is write, 11 is erase, and 00 is a special command.
- R2: With organisation select high the array is 2^WORD_AW 16-bit words addressed by WORD_AW bits. With it low the array is 2^(WORD_AW+1) bytes addressed by WORD_AW+1 bits. Word a is the same storage as byte 2a (its upper half) and byte 2a+1 (its lower half).
- R3: On the rising serial clock edge that shifts in the last address bit of a read, data out is enabled and shows a single 0. Each following rising edge presents the next bit of the addressed word, most significant bit first.
- R4: The write-enable latch is clear after reset. Erase, write, erase-all and write-all change nothing and start no programming period while it is clear. A special command whose two upper address bits are 11 sets the latch, and 00 clears it. Read works in either case.
- R5: Erase sets the addressed word to all ones and erase-all sets the whole array to ones. Write stores the data bits that follow the address, and write-all stores them in every word (special command with upper address bits 01; 10 selects erase-all). No erase is needed before a write.
- R6: Programming begins on the rising serial clock edge of the final bit: the last data bit for write and write-all, and the last address bit for erase and erase-all. If chip select drops before that edge, the array is unchanged and no programming period starts.
- R7: After programming begins, data out is enabled whenever chip select is high. It shows 0 for BUSY_CYCLES clock cycles and 1 afterwards. With chip select low it is high impedance. A start bit received once the device is ready returns it to high impedance.
- R8: Chip select low discards a partly shifted instruction, so the next start bit begins a fresh frame.
- R9: During a programming period, start bits and complete commands are ignored.
- R10: After reset every bit of the array is 1 and data out is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; its rising edges shift bits |
| di | input | 1 | Serial data in |
| org | input | 1 | Organisation select: 1 for 16-bit words, 0 for bytes |
| dout | output | 1 | Serial data out value |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |

## Verification
A wrong bit count or a mis-sized address field shows up within a single frame. The dummy bit lands a cycle early or late, or a read returns the neighbouring word, and the checks that read back in the other organisation expose any mismatch in the byte-to-word mapping. A write-enable latch in the wrong state shows up the next time the array is read back, and a status flag or timer in the wrong state is visible on the data output line as soon as a poll is made with chip select high. A busy period that fails to block commands leaves a changed word that a later read reveals.

// File: rtl/se_pkg.sv
package se_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_READ
  } se_state_t;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  // sub-commands in the two upper address bits of a special command
  localparam logic [1:0] SUB_WDIS  = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERALL = 2'b10;
  localparam logic [1:0] SUB_WEN   = 2'b11;

  // address length in bits for the selected organisation
  function automatic int unsigned se_addr_len(input logic org, input int unsigned word_aw);
    return org ? word_aw : word_aw + 1;
  endfunction

  // data length in bits for the selected organisation
  function automatic int unsigned se_data_len(input logic org);
    return org ? 16 : 8;
  endfunction

endpackage

// File: rtl/se_sk_edge.sv
module se_sk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic bit_stb
);
  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  // one strobe per rising serial clock edge while selected (R1)
  assign bit_stb = cs && sk && !sk_q;
endmodule

// File: rtl/se_prog_timer.sv
module se_prog_timer #(
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned TW = $clog2(BUSY_CYCLES + 1);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= TW'(BUSY_CYCLES);
    else if (remain != '0)   remain <= remain - TW'(1);
  end

  // busy for BUSY_CYCLES cycles after the start edge (R7)
  assign busy = (remain != '0);
endmodule

// File: rtl/se_store.sv
module se_store #(
  parameter int unsigned WORD_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 org,
  input  logic [WORD_AW:0]     rd_addr,
  output logic [15:0]          rd_word,
  input  logic                 wr_one,
  input  logic                 wr_all,
  input  logic [WORD_AW:0]     wr_addr,
  input  logic [15:0]          wr_data
);
  localparam int unsigned BYTE_AW = WORD_AW + 1;
  localparam int unsigned BYTES   = 1 << BYTE_AW;

  logic [7:0] mem [BYTES];

  // byte 2a holds the upper half of word a, byte 2a+1 the lower half (R2)
  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    localparam logic [BYTE_AW-1:0] IDX = BYTE_AW'(g);
    logic hit;
    logic [7:0] wval;
    assign hit  = wr_all ||
                  (wr_one && (org ? (wr_addr[WORD_AW-1:0] == IDX[BYTE_AW-1:1])
                                  : (wr_addr == IDX)));
    assign wval = (org && !IDX[0]) ? wr_data[15:8] : wr_data[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= 8'hFF;   // erased after reset (R10)
      else if (hit) mem[g] <= wval;
    end
  end

  always_comb begin
    if (org) rd_word = {mem[{rd_addr[WORD_AW-1:0], 1'b0}], mem[{rd_addr[WORD_AW-1:0], 1'b1}]};
    else     rd_word = {mem[rd_addr], 8'h00};
  end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int unsigned WORD_AW     = 6,
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic dout,
  output logic dout_oe
);
  import se_pkg::*;

  localparam int unsigned BYTE_AW = WORD_AW + 1;
  localparam int unsigned SH_W    = 2 + BYTE_AW + 16;
  localparam int unsigned CW      = $clog2(SH_W + 1);

  logic               bit_stb;
  logic               busy;
  se_state_t          state;
  logic [CW-1:0]      cnt, cnt_nx, aw_len, dw_len;
  logic [SH_W-1:0]    sh, sh_nx, op_field, sub_field;
  logic [1:0]         op_nx, sub_nx;
  logic [BYTE_AW-1:0] addr_mask, addr_nx, lat_addr, wr_addr;
  logic               lat_all, wen, poll;
  logic [16:0]        rd_sh;
  logic [15:0]        rd_word, data_nx, wr_data;

  // named internal events
  logic hdr_done, data_done, ev_start;
  logic prog_erase, prog_eral, prog_write, prog_wral, prog_start;
  logic wr_one, wr_all;

  se_sk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sk      (sk),
    .bit_stb (bit_stb)
  );

  se_prog_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_start),
    .busy  (busy)
  );

  se_store #(.WORD_AW(WORD_AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .org     (org),
    .rd_addr (addr_nx),
    .rd_word (rd_word),
    .wr_one  (wr_one),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  // frame arithmetic: field lengths follow the organisation (R2)
  assign aw_len    = CW'(se_addr_len(org, WORD_AW));
  assign dw_len    = CW'(se_data_len(org));
  assign sh_nx     = {sh[SH_W-2:0], di};
  assign cnt_nx    = cnt + CW'(1);
  assign op_field  = sh_nx >> aw_len;
  assign sub_field = sh_nx >> (aw_len - CW'(2));
  assign op_nx     = op_field[1:0];
  assign sub_nx    = sub_field[1:0];
  assign addr_mask = (BYTE_AW'(1) << aw_len) - BYTE_AW'(1);
  assign addr_nx   = sh_nx[BYTE_AW-1:0] & addr_mask;
  assign data_nx   = org ? sh_nx[15:0] : {8'h00, sh_nx[7:0]};

  assign hdr_done  = bit_stb && (state == ST_CMD)  && (cnt_nx == aw_len + CW'(2));
  assign data_done = bit_stb && (state == ST_DATA) && (cnt_nx == aw_len + dw_len + CW'(2));
  // start bits ignored while programming (R9)
  assign ev_start  = bit_stb && (state == ST_IDLE) && di && !busy;

  // programming events, all gated by the write-enable latch (R4, R6)
  assign prog_erase = hdr_done && (op_nx == OP_ERASE) && wen;
  assign prog_eral  = hdr_done && (op_nx == OP_SPECIAL) && (sub_nx == SUB_ERALL) && wen;
  assign prog_write = data_done && !lat_all && wen;
  assign prog_wral  = data_done &&  lat_all && wen;
  assign prog_start = prog_erase || prog_eral || prog_write || prog_wral;

  assign wr_one  = prog_erase || prog_write;
  assign wr_all  = prog_eral  || prog_wral;
  assign wr_addr = prog_erase ? addr_nx : lat_addr;
  assign wr_data = (prog_erase || prog_eral) ? 16'hFFFF : data_nx;   // R5

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      wen      <= 1'b0;
      poll     <= 1'b0;
      rd_sh    <= '0;
      lat_addr <= '0;
      lat_all  <= 1'b0;
    end else if (!cs) begin
      // deselect drops any partial frame (R8)
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (bit_stb) begin
      case (state)
        ST_IDLE: begin
          if (ev_start) begin
            state <= ST_CMD;
            cnt   <= '0;
            poll  <= 1'b0;
          end
        end
        ST_CMD: begin
          sh  <= sh_nx;
          cnt <= cnt_nx;
          if (hdr_done) begin
            state <= ST_IDLE;
            case (op_nx)
              OP_READ: begin
                state <= ST_READ;
                rd_sh <= {1'b0, rd_word};   // dummy zero first (R3)
              end
              OP_WRITE: begin
                state    <= ST_DATA;
                lat_addr <= addr_nx;
                lat_all  <= 1'b0;
              end
              OP_ERASE: poll <= wen;
              default: begin
                case (sub_nx)
                  SUB_WEN:   wen  <= 1'b1;
                  SUB_WDIS:  wen  <= 1'b0;
                  SUB_ERALL: poll <= wen;
                  default: begin
                    state   <= ST_DATA;
                    lat_all <= 1'b1;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          sh  <= sh_nx;
          cnt <= cnt_nx;
          if (data_done) begin
            state <= ST_IDLE;
            poll  <= wen;
          end
        end
        default: rd_sh <= {rd_sh[15:0], 1'b0};
      endcase
    end
  end

  // status or read data, released while deselected (R7)
  assign dout_oe = cs && ((state == ST_READ) || poll);
  assign dout    = (state == ST_READ) ? rd_sh[16] : !busy;
endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              bit_stb,
  input logic              busy,
  input logic              wen,
  input se_pkg::se_state_t st,
  input logic              dout,
  input logic              wr_one,
  input logic              wr_all
);
  import se_pkg::*;

  assert_prog_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bit_stb));

  assert_prog_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == ST_IDLE) |=> (st == ST_IDLE));

  assert_read_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && $past(st) != ST_READ) |-> !dout);

  assert_cs_low_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (st == ST_IDLE));

  assert_single_write_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_one, wr_all}));
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs      (cs),
  .bit_stb (bit_stb),
  .busy    (busy),
  .wen     (wen),
  .st      (state),
  .dout    (dout),
  .wr_one  (wr_one),
  .wr_all  (wr_all)
);

// File: tb/serial_eeprom_slave_tb_top.sv
module serial_eeprom_slave_tb_top;
  localparam int unsigned WA   = 6;
  localparam int unsigned BUSY = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, dout_oe;
  wire  dline = dout_oe ? dout : 1'bz;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_eeprom_slave #(.WORD_AW(WA), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic int unsigned aw();
    return org ? WA : WA + 1;
  endfunction
  function automatic int unsigned dw();
    return org ? 16 : 8;
  endfunction

  task automatic chk_word(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: read %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_line(input string req, input logic exp);
    checks++;
    if (dline !== exp) begin
      fails++;
      $display("FAIL %s: data out %b expected %b", req, dline, exp);
    end
  endtask

  task automatic gap();
    repeat (4) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    @(negedge clk) di = b;
    @(negedge clk) sk = 1'b1;
    repeat (3) @(negedge clk);
    sk = 1'b0;
    @(negedge clk) di = 1'b0;
  endtask

  task automatic rbit(output logic b);
    @(negedge clk) sk = 1'b1;
    repeat (3) @(negedge clk);
    b = dline;
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic shdr(input logic [1:0] op, input int unsigned addr);
    sbit(1'b1);
    sbit(op[1]);
    sbit(op[0]);
    for (int i = int'(aw()) - 1; i >= 0; i--) sbit(addr[i]);
  endtask

  task automatic rd(input int unsigned addr, input int lead, output logic [15:0] w);
    logic b;
    @(negedge clk) cs = 1'b1;
    for (int i = 0; i < lead; i++) sbit(1'b0);
    shdr(2'b10, addr);
    chk_line("R3 dummy zero", 1'b0);
    w = '0;
    for (int i = 0; i < int'(dw()); i++) begin
      rbit(b);
      w = {w[14:0], b};
    end
    @(negedge clk) cs = 1'b0;
    gap();
  endtask

  task automatic finish_ready(input string req);
    repeat (BUSY + 8) @(negedge clk);
    chk_line(req, 1'b1);
    sbit(1'b1);
    chk_line("R7 start bit releases line", 1'bz);
    @(negedge clk) cs = 1'b0;
    gap();
  endtask

  task automatic prog(input logic [1:0] op, input int unsigned addr, input logic [15:0] data,
                      input bit has_data, input bit expect_prog, input bit auto_finish,
                      input string req);
    @(negedge clk) cs = 1'b1;
    shdr(op, addr);
    if (has_data)
      for (int i = int'(dw()) - 1; i >= 0; i--) sbit(data[i]);
    if (expect_prog) begin
      chk_line(req, 1'b0);
      if (auto_finish) finish_ready(req);
    end else begin
      chk_line(req, 1'bz);
      @(negedge clk) cs = 1'b0;
      gap();
    end
  endtask

  function automatic int unsigned spc(input logic [1:0] sub);
    return int'(sub) << (aw() - 2);
  endfunction

  task automatic special(input logic [1:0] sub);
    @(negedge clk) cs = 1'b1;
    shdr(2'b00, spc(sub));
    @(negedge clk) cs = 1'b0;
    gap();
  endtask

  // R10, R1: reset state and leading zeros ignored
  task automatic t_reset();
    logic [15:0] w;
    chk_line("R10 released after reset", 1'bz);
    rd(3, 3, w);
    chk_word("R10 R1 erased word after leading zeros", w, 16'hFFFF);
  endtask

  // R4: protected after reset
  task automatic t_protect();
    logic [15:0] w;
    prog(2'b01, 5, 16'hA55A, 1, 0, 0, "R4 no status while protected");
    rd(5, 0, w);
    chk_word("R4 write ignored while protected", w, 16'hFFFF);
  endtask

  // R5, R7: enabled write with status polling
  task automatic t_write();
    logic [15:0] w;
    special(2'b11);
    prog(2'b01, 5, 16'hA55A, 1, 1, 1, "R7 busy then ready after write");
    rd(5, 0, w);
    chk_word("R5 write stored", w, 16'hA55A);
    prog(2'b01, 63, 16'h0001, 1, 1, 1, "R7 busy then ready at top address");
    rd(63, 0, w);
    chk_word("R5 write top address", w, 16'h0001);
  endtask

  // R9: commands during programming ignored
  task automatic t_busy();
    logic [15:0] w;
    prog(2'b01, 9, 16'h1234, 1, 1, 0, "R7 busy after write");
    @(negedge clk) cs = 1'b0;
    gap();
    @(negedge clk) cs = 1'b1;
    gap();
    shdr(2'b01, 7);
    for (int i = 15; i >= 0; i--) sbit(1'b0);
    chk_line("R9 start bit ignored while busy", 1'b0);
    finish_ready("R7 ready after busy period");
    rd(7, 0, w);
    chk_word("R9 write during busy ignored", w, 16'hFFFF);
    rd(9, 0, w);
    chk_word("R5 first write kept", w, 16'h1234);
  endtask

  // R6, R8: abort before final bit, and partial frame discarded
  task automatic t_abort();
    logic [15:0] w;
    @(negedge clk) cs = 1'b1;
    shdr(2'b01, 8);
    for (int i = 15; i >= 1; i--) sbit(1'b0);
    @(negedge clk) cs = 1'b0;
    gap();
    chk_line("R6 no status after abort", 1'bz);
    rd(8, 0, w);
    chk_word("R6 aborted write left word unchanged", w, 16'hFFFF);
    @(negedge clk) cs = 1'b1;
    sbit(1'b1); sbit(1'b1); sbit(1'b0); sbit(1'b1);
    @(negedge clk) cs = 1'b0;
    gap();
    rd(5, 0, w);
    chk_word("R8 fresh frame after deselect", w, 16'hA55A);
  endtask

  // R5, R7: erase with deselect during polling
  task automatic t_erase();
    logic [15:0] w;
    prog(2'b11, 5, 16'h0000, 0, 1, 0, "R6 erase starts on last address bit");
    @(negedge clk) cs = 1'b0;
    gap();
    chk_line("R7 released while deselected", 1'bz);
    repeat (BUSY + 8) @(negedge clk);
    @(negedge clk) cs = 1'b1;
    gap();
    chk_line("R7 ready shown on reselect", 1'b1);
    sbit(1'b1);
    chk_line("R7 start bit releases line", 1'bz);
    @(negedge clk) cs = 1'b0;
    gap();
    rd(5, 0, w);
    chk_word("R5 erase sets ones", w, 16'hFFFF);
  endtask

  // R5: write-all and erase-all
  task automatic t_all();
    logic [15:0] w;
    prog(2'b00, spc(2'b01), 16'h5AA5, 1, 1, 1, "R7 status after write-all");
    rd(0, 0, w);
    chk_word("R5 write-all word 0", w, 16'h5AA5);
    rd(40, 0, w);
    chk_word("R5 write-all word 40", w, 16'h5AA5);
    prog(2'b00, spc(2'b10), 16'h0000, 0, 1, 1, "R7 status after erase-all");
    rd(0, 0, w);
    chk_word("R5 erase-all word 0", w, 16'hFFFF);
    rd(63, 0, w);
    chk_word("R5 erase-all word 63", w, 16'hFFFF);
  endtask

  // R2: byte organisation and mapping onto words
  task automatic t_org8();
    logic [15:0] w;
    org = 1'b0;
    gap();
    prog(2'b01, 7, 16'h003C, 1, 1, 1, "R7 status after byte write");
    rd(7, 0, w);
    chk_word("R2 byte read", w, 16'h003C);
    prog(2'b01, 127, 16'h0081, 1, 1, 1, "R7 status after top byte write");
    rd(127, 0, w);
    chk_word("R2 top byte address", w, 16'h0081);
    org = 1'b1;
    gap();
    rd(3, 0, w);
    chk_word("R2 word 3 holds bytes 6 and 7", w, 16'hFF3C);
    rd(63, 0, w);
    chk_word("R2 word 63 holds bytes 126 and 127", w, 16'hFF81);
  endtask

  // R4: disable blocks programming, read still works
  task automatic t_disable();
    logic [15:0] w;
    special(2'b00);
    prog(2'b01, 9, 16'h0000, 1, 0, 0, "R4 no status after disable");
    prog(2'b00, spc(2'b10), 16'h0000, 0, 0, 0, "R4 erase-all blocked");
    rd(9, 0, w);
    chk_word("R4 write blocked after disable", w, 16'hFFFF);
    rd(3, 0, w);
    chk_word("R4 read while disabled", w, 16'hFF3C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    gap();
    t_reset();
    t_protect();
    t_write();
    t_busy();
    t_abort();
    t_erase();
    t_all();
    t_org8();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, 0 expected pending");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule